// File: doc/BRIEF.md
# Access Rights and Protection Checker

This block decides whether one memory access may go ahead once the translation lookaside buffer has been searched. It takes the result of that search (a hit flag and the fields of the matching entry), the privilege level of the running code and the kind of access requested. It returns two things: the set of rights the entry grants, and a single fault code. It has no clock and no state. The address translation and the storage of entries are handled by other blocks. This block only judges the result of the lookup.

The entry carries a 3-bit page type, two privilege bounds, an access identifier and three control bits: dirty, break and trap. The rights are first derived from the type and the bounds. If the page is not public and protection-ID checking is on, the access identifier is then compared against a set of protection-ID slots, and the first matching slot may also take away write permission. Finally the dirty, break and trap bits are applied. Each of these can raise its own fault and can also narrow the rights that are reported, so that a later access is forced back through the full check.

Top module: `access_rights_checker`

## Requirements
- R1: For a hit entry, read is granted when priv_i <= upper bound, write when priv_i <= lower bound, and execute when lower bound <= priv_i <= upper bound. Values are unsigned, and a smaller number means more privilege. Rights bits are [0] read, [1] write, [2] execute.
- R2: Page type 0 grants read only. Type 1 grants read and write. Type 2 grants read and execute. Type 3 grants all three. Types 4 to 7 grant execute only. Each right is still subject to the R1 comparison.
- R3: When hit_i is low, rights_o is 0. fault_o is 1 (instruction miss) for an execute access and 2 (data miss) for any other access. Access codes are 0 read, 1 write, 2 execute.
- R4: Each protection-ID slot is MATCH_W+1 bits wide. Bits [MATCH_W:1] form the identifier, and a slot matches when they equal the low MATCH_W bits of the entry's access ID. If bit 0 of the matching slot is set, the slot grants read and execute. Otherwise it grants read, write and execute.
- R5: Slot k sits at bits [k*(MATCH_W+1) +: MATCH_W+1] of pid_slots_i, and the first matching slot (lowest k) decides. With WIDE=1 there are two slots per register: slot 2r is register r's low half and slot 2r+1 is its high half, so a register's low half is tried before its high half. With WIDE=0 there is one slot per register.
- R6: The protection-ID check is skipped when the entry's access ID is all zeros (a public page) or when pid_en_i is low.
- R7: When the protection-ID check applies and no matching slot grants the requested access, fault_o is 3 for an execute access and 4 otherwise. In that case rights_o is the R1/R2 set. When the check passes, the rights are narrowed to the matching slot's set.
- R8: When the requested access is not in the rights, fault_o is 5. rights_o then reports the rights after any protection-ID narrowing, and R9/R10 are not applied.
- R9: Once R7 and R8 have passed, three checks follow. A clear dirty bit on a write gives fault 6. A set break bit on a write gives fault 7. A set trap bit on a read or a write gives fault 8. Where several apply, the later check in that order wins. Otherwise fault_o is 0.
- R10: In the same case as R9, a clear dirty bit or a set break bit removes write from rights_o. A set trap bit leaves only execute.
- R11: Access code 3 is treated exactly like a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hit_i | input | 1 | Lookup found a valid entry |
| acc_type_i | input | 2 | Requested access: 0 read, 1 write, 2 execute, 3 read |
| priv_i | input | PRIV_W (2) | Current privilege level |
| ent_type_i | input | 3 | Entry page type |
| ent_pl_hi_i | input | PRIV_W (2) | Entry upper privilege bound (read limit) |
| ent_pl_lo_i | input | PRIV_W (2) | Entry lower privilege bound (write limit) |
| ent_aid_i | input | AID_W (31) | Entry access identifier, zero for a public page |
| ent_dirty_i | input | 1 | Entry dirty bit |
| ent_break_i | input | 1 | Entry break bit |
| ent_trap_i | input | 1 | Entry trap (reference) bit |
| pid_en_i | input | 1 | Protection-ID checking enabled |
| pid_slots_i | input | NUM_PID*(WIDE+1)*(MATCH_W+1) (136) | Packed protection-ID slots |
| rights_o | output | 3 | Granted rights {execute, write, read} |
| fault_o | output | 4 | Fault code, 0 for none |

## Verification
The bench builds two copies of the block side by side, both fed the same stimulus. One uses the defaults (WIDE=1, four registers, 16-bit match). The other uses WIDE=0 with the same register count. With both copies present, one vector can place a write-disabled match in a register's high half and a full match in the next register's low half. The wide copy must then take the first match, and the narrow copy, which cannot see high halves, must take the second. The short privilege field puts every bound relation within reach of directed vectors. The same vectors also stack the dirty, break and trap bits so that each override in the final checks is observed, and a seeded random run covers the remaining combinations.

// File: rtl/ar_pkg.sv
package ar_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_ALT   = 2'd3
   } acc_t;

   typedef enum logic [3:0] {
      FLT_NONE   = 4'd0,
      FLT_IMISS  = 4'd1,
      FLT_DMISS  = 4'd2,
      FLT_IPID   = 4'd3,
      FLT_DPID   = 4'd4,
      FLT_RIGHTS = 4'd5,
      FLT_DIRTY  = 4'd6,
      FLT_BREAK  = 4'd7,
      FLT_REF    = 4'd8
   } fault_t;

   localparam int RB_R = 0;
   localparam int RB_W = 1;
   localparam int RB_X = 2;

   localparam logic [2:0] RIGHTS_ALL  = 3'b111;
   localparam logic [2:0] RIGHTS_RX   = 3'b101;
   localparam logic [2:0] RIGHTS_XO   = 3'b100;
   localparam logic [2:0] RIGHTS_NONE = 3'b000;

   function automatic logic [2:0] req_mask(input acc_t a);
      case (a)
         ACC_WRITE: req_mask = 3'b010;
         ACC_EXEC:  req_mask = 3'b100;
         default:   req_mask = 3'b001;
      endcase
   endfunction

endpackage

// File: rtl/ar_rights_decode.sv
module ar_rights_decode
   import ar_pkg::*;
#(
   parameter int PRIV_W = 2
) (
   input  logic [PRIV_W-1:0] priv_i,
   input  logic [2:0]        type_i,
   input  logic [PRIV_W-1:0] pl_hi_i,
   input  logic [PRIV_W-1:0] pl_lo_i,
   output logic [2:0]        rights_o
);

   logic may_r, may_w, may_x;

   always_comb begin
      may_r = (priv_i <= pl_hi_i);
      may_w = (priv_i <= pl_lo_i);
      may_x = (pl_lo_i <= priv_i) && (priv_i <= pl_hi_i);
      rights_o = RIGHTS_NONE;
      case (type_i)
         3'd0: rights_o[RB_R] = may_r;
         3'd1: begin
            rights_o[RB_R] = may_r;
            rights_o[RB_W] = may_w;
         end
         3'd2: begin
            rights_o[RB_R] = may_r;
            rights_o[RB_X] = may_x;
         end
         3'd3: begin
            rights_o[RB_R] = may_r;
            rights_o[RB_W] = may_w;
            rights_o[RB_X] = may_x;
         end
         default: rights_o[RB_X] = may_x;
      endcase
   end

   always_comb begin
      if (rights_o[RB_X])
         assert_exec_window_R1: assert ((pl_lo_i <= priv_i) && (priv_i <= pl_hi_i))
            else $error("execute granted outside the privilege window");
      if (type_i[2])
         assert_exec_only_R2: assert (rights_o[RB_R] == 1'b0 && rights_o[RB_W] == 1'b0)
            else $error("upper page types granted data rights");
   end

endmodule

// File: rtl/ar_pid_match.sv
module ar_pid_match
   import ar_pkg::*;
#(
   parameter int NSLOT   = 8,
   parameter int MATCH_W = 16,
   parameter int AID_W   = 31
) (
   input  logic [AID_W-1:0]             aid_i,
   input  logic [NSLOT*(MATCH_W+1)-1:0] slots_i,
   output logic                         found_o,
   output logic [2:0]                   rights_o
);

   localparam int SLOT_W = MATCH_W + 1;

   logic [NSLOT-1:0] hit_v;
   logic [NSLOT-1:0] wd_v;
   logic [NSLOT-1:0] first_v;

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      logic [SLOT_W-1:0] slot;
      assign slot     = slots_i[k*SLOT_W +: SLOT_W];
      assign hit_v[k] = (slot[SLOT_W-1:1] == aid_i[MATCH_W-1:0]);
      assign wd_v[k]  = slot[0];
   end

   // Walk from the last slot down so that the lowest match is kept.
   always_comb begin
      found_o  = 1'b0;
      first_v  = '0;
      rights_o = RIGHTS_NONE;
      for (int k = NSLOT - 1; k >= 0; k--) begin
         if (hit_v[k]) begin
            found_o    = 1'b1;
            first_v    = '0;
            first_v[k] = 1'b1;
            rights_o   = wd_v[k] ? RIGHTS_RX : RIGHTS_ALL;
         end
      end
   end

   always_comb begin
      assert_single_winner_R5: assert ($onehot0(first_v))
         else $error("more than one slot selected");
      assert_found_any_R4: assert (found_o == (|hit_v))
         else $error("match flag disagrees with slot compares");
      if (found_o)
         assert_no_earlier_R5: assert (((first_v - 1'b1) & hit_v) == '0)
            else $error("a lower slot also matched");
   end

endmodule

// File: rtl/ar_fault_resolve.sv
module ar_fault_resolve
   import ar_pkg::*;
(
   input  logic       hit_i,
   input  acc_t       acc_i,
   input  logic [2:0] base_rights_i,
   input  logic       pid_active_i,
   input  logic       pid_found_i,
   input  logic [2:0] pid_rights_i,
   input  logic       dirty_i,
   input  logic       break_i,
   input  logic       trap_i,
   output logic [2:0] rights_o,
   output fault_t     fault_o
);

   logic [2:0] req;
   logic [2:0] eff;
   logic       is_exec, is_write;

   always_comb begin
      req      = req_mask(acc_i);
      is_exec  = (acc_i == ACC_EXEC);
      is_write = (acc_i == ACC_WRITE);
      eff      = base_rights_i;
      rights_o = RIGHTS_NONE;
      fault_o  = FLT_NONE;
      if (!hit_i) begin
         fault_o = is_exec ? FLT_IMISS : FLT_DMISS;
      end else if (pid_active_i && !(pid_found_i && ((req & pid_rights_i) != 3'b000))) begin
         rights_o = base_rights_i;
         fault_o  = is_exec ? FLT_IPID : FLT_DPID;
      end else begin
         if (pid_active_i)
            eff = base_rights_i & pid_rights_i;
         if ((req & eff) == 3'b000) begin
            rights_o = eff;
            fault_o  = FLT_RIGHTS;
         end else begin
            if (!dirty_i) begin
               if (is_write) fault_o = FLT_DIRTY;
               eff[RB_W] = 1'b0;
            end
            if (break_i) begin
               if (is_write) fault_o = FLT_BREAK;
               eff[RB_W] = 1'b0;
            end
            if (trap_i) begin
               if (!is_exec) fault_o = FLT_REF;
               eff = eff & RIGHTS_XO;
            end
            rights_o = eff;
         end
      end
   end

   always_comb begin
      if (!hit_i)
         assert_miss_quiet_R3: assert (rights_o == RIGHTS_NONE &&
                                       (fault_o == FLT_IMISS || fault_o == FLT_DMISS))
            else $error("miss reported rights or a wrong code");
      if (fault_o == FLT_NONE)
         assert_clean_granted_R8: assert ((rights_o & req_mask(acc_i)) != 3'b000)
            else $error("no fault but requested right absent");
      if (hit_i && trap_i && (fault_o == FLT_NONE || fault_o == FLT_REF))
         assert_trap_exec_only_R10: assert ((rights_o & ~RIGHTS_XO) == 3'b000)
            else $error("trap page kept data rights");
      if (hit_i && trap_i && acc_i != ACC_EXEC &&
          !(fault_o inside {FLT_IPID, FLT_DPID, FLT_RIGHTS}))
         assert_ref_overrides_R9: assert (fault_o == FLT_REF)
            else $error("reference fault lost its priority");
   end

endmodule

// File: rtl/access_rights_checker.sv
module access_rights_checker
   import ar_pkg::*;
#(
   parameter int PRIV_W  = 2,
   parameter int AID_W   = 31,
   parameter int MATCH_W = 16,
   parameter int NUM_PID = 4,
   parameter bit WIDE    = 1'b1,
   localparam int HALVES = WIDE ? 2 : 1,
   localparam int NSLOT  = NUM_PID * HALVES,
   localparam int SLOTS_W = NSLOT * (MATCH_W + 1)
) (
   input  logic               hit_i,
   input  logic [1:0]         acc_type_i,
   input  logic [PRIV_W-1:0]  priv_i,
   input  logic [2:0]         ent_type_i,
   input  logic [PRIV_W-1:0]  ent_pl_hi_i,
   input  logic [PRIV_W-1:0]  ent_pl_lo_i,
   input  logic [AID_W-1:0]   ent_aid_i,
   input  logic               ent_dirty_i,
   input  logic               ent_break_i,
   input  logic               ent_trap_i,
   input  logic               pid_en_i,
   input  logic [SLOTS_W-1:0] pid_slots_i,
   output logic [2:0]         rights_o,
   output logic [3:0]         fault_o
);

   if (PRIV_W < 1) begin : g_bad_priv
      $error("PRIV_W must be at least 1");
   end
   if (MATCH_W < 1 || MATCH_W > AID_W) begin : g_bad_match
      $error("MATCH_W must lie between 1 and AID_W");
   end
   if (NUM_PID < 1) begin : g_bad_num
      $error("NUM_PID must be at least 1");
   end

   logic [2:0] base_rights;
   logic [2:0] pid_rights;
   logic       pid_found;
   logic       pid_active;
   fault_t     fault_e;

   assign pid_active = pid_en_i && (ent_aid_i != '0);

   ar_rights_decode #(.PRIV_W(PRIV_W)) u_decode (
      .priv_i   (priv_i),
      .type_i   (ent_type_i),
      .pl_hi_i  (ent_pl_hi_i),
      .pl_lo_i  (ent_pl_lo_i),
      .rights_o (base_rights)
   );

   ar_pid_match #(
      .NSLOT   (NSLOT),
      .MATCH_W (MATCH_W),
      .AID_W   (AID_W)
   ) u_pid (
      .aid_i    (ent_aid_i),
      .slots_i  (pid_slots_i),
      .found_o  (pid_found),
      .rights_o (pid_rights)
   );

   ar_fault_resolve u_resolve (
      .hit_i         (hit_i),
      .acc_i         (acc_t'(acc_type_i)),
      .base_rights_i (base_rights),
      .pid_active_i  (pid_active),
      .pid_found_i   (pid_found),
      .pid_rights_i  (pid_rights),
      .dirty_i       (ent_dirty_i),
      .break_i       (ent_break_i),
      .trap_i        (ent_trap_i),
      .rights_o      (rights_o),
      .fault_o       (fault_e)
   );

   assign fault_o = fault_e;

   always_comb begin
      if (hit_i && !pid_active && fault_e inside {FLT_IPID, FLT_DPID})
         assert_public_skips_R6: assert (1'b0)
            else $error("protection-ID fault on an unchecked page");
      if (fault_e == FLT_DIRTY || fault_e == FLT_BREAK)
         assert_write_cleared_R10: assert (!rights_o[RB_W] && acc_type_i == 2'd1)
            else $error("dirty or break fault without write removal");
   end

endmodule

// File: tb/access_rights_checker_bench.sv
module access_rights_checker_bench;

   localparam int MW  = 16;
   localparam int SW  = MW + 1;
   localparam int NP  = 4;

   localparam logic [3:0] E_NONE = 4'd0, E_IMISS = 4'd1, E_DMISS = 4'd2,
                          E_IPID = 4'd3, E_DPID = 4'd4, E_RIGHTS = 4'd5,
                          E_DIRTY = 4'd6, E_BREAK = 4'd7, E_REF = 4'd8;

   typedef struct packed {
      logic              hit;
      logic [1:0]        acc;
      logic [1:0]        priv;
      logic [2:0]        ty;
      logic [1:0]        hi;
      logic [1:0]        lo;
      logic [30:0]       aid;
      logic              d, b, t, pen;
      logic [7:0][SW-1:0] slots;
   } vec_t;

   typedef struct {
      logic [2:0] wr; logic [3:0] wf;
      logic [2:0] nr; logic [3:0] nf;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   vec_t cur = '0;
   logic [2:0] w_rights, n_rights;
   logic [3:0] w_fault, n_fault;
   logic [NP*SW-1:0] narrow_slots;

   always_comb
      for (int r = 0; r < NP; r++) narrow_slots[r*SW +: SW] = cur.slots[2*r];

   access_rights_checker u_access_rights_checker (
      .hit_i(cur.hit), .acc_type_i(cur.acc), .priv_i(cur.priv), .ent_type_i(cur.ty),
      .ent_pl_hi_i(cur.hi), .ent_pl_lo_i(cur.lo), .ent_aid_i(cur.aid),
      .ent_dirty_i(cur.d), .ent_break_i(cur.b), .ent_trap_i(cur.t),
      .pid_en_i(cur.pen), .pid_slots_i(cur.slots),
      .rights_o(w_rights), .fault_o(w_fault));

   access_rights_checker #(.WIDE(1'b0)) u_narrow (
      .hit_i(cur.hit), .acc_type_i(cur.acc), .priv_i(cur.priv), .ent_type_i(cur.ty),
      .ent_pl_hi_i(cur.hi), .ent_pl_lo_i(cur.lo), .ent_aid_i(cur.aid),
      .ent_dirty_i(cur.d), .ent_break_i(cur.b), .ent_trap_i(cur.t),
      .pid_en_i(cur.pen), .pid_slots_i(narrow_slots),
      .rights_o(n_rights), .fault_o(n_fault));

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;
   exp_t q[$];

   // Expected result straight from the requirement text.
   function automatic logic [6:0] expect_of(input vec_t v, input bit wide);
      logic [2:0] req, rt, base, pr;
      logic [3:0] f;
      bit ex, wr, found, rr, ww, xx;
      ex = (v.acc == 2'd2);
      wr = (v.acc == 2'd1);
      req = wr ? 3'b010 : (ex ? 3'b100 : 3'b001);
      if (!v.hit) return {3'b000, ex ? E_IMISS : E_DMISS};
      rr = v.priv <= v.hi;
      ww = v.priv <= v.lo;
      xx = (v.lo <= v.priv) && (v.priv <= v.hi);
      case (v.ty)
         3'd0: base = {1'b0, 1'b0, rr};
         3'd1: base = {1'b0, ww, rr};
         3'd2: base = {xx, 1'b0, rr};
         3'd3: base = {xx, ww, rr};
         default: base = {xx, 2'b00};
      endcase
      rt = base;
      if (v.pen && v.aid != 0) begin
         found = 0; pr = 0;
         for (int k = 0; k < 8; k++)
            if (!found && (wide || k % 2 == 0) && v.slots[k][SW-1:1] == v.aid[MW-1:0]) begin
               found = 1;
               pr = v.slots[k][0] ? 3'b101 : 3'b111;
            end
         if (!found || (pr & req) == 0) return {base, ex ? E_IPID : E_DPID};
         rt = base & pr;
      end
      if ((rt & req) == 0) return {rt, E_RIGHTS};
      f = E_NONE;
      if (!v.d) begin if (wr) f = E_DIRTY; rt[1] = 0; end
      if (v.b)  begin if (wr) f = E_BREAK; rt[1] = 0; end
      if (v.t)  begin if (!ex) f = E_REF;  rt = rt & 3'b100; end
      return {rt, f};
   endfunction

   task automatic apply(input vec_t v, input string tag);
      exp_t e;
      logic [6:0] w, n;
      w = expect_of(v, 1'b1);
      n = expect_of(v, 1'b0);
      e.wr = w[6:4]; e.wf = w[3:0]; e.nr = n[6:4]; e.nf = n[3:0]; e.tag = tag;
      @(posedge clk);
      cur = v;
      q.push_back(e);
   endtask

   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         vectors++;
         if (w_rights !== e.wr || w_fault !== e.wf) begin
            errors++;
            $display("FAIL %s wide: rights %b fault %0d, expected rights %b fault %0d",
                     e.tag, w_rights, w_fault, e.wr, e.wf);
         end
         if (n_rights !== e.nr || n_fault !== e.nf) begin
            errors++;
            $display("FAIL %s narrow: rights %b fault %0d, expected rights %b fault %0d",
                     e.tag, n_rights, n_fault, e.nr, e.nf);
         end
      end
   end

   function automatic vec_t base_hit();
      vec_t v = '0;
      v.hit = 1; v.ty = 3'd3; v.hi = 2'd3; v.lo = 2'd3; v.priv = 2'd0; v.d = 1;
      return v;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      vec_t v;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      apply('0, "R3 idle data miss");
      v = '0; v.acc = 2'd2; apply(v, "R3 fetch miss");
      v = base_hit(); v.priv = 2'd2; v.hi = 2'd1; v.lo = 2'd0;
      apply(v, "R1 read above upper bound");
      v = base_hit(); v.acc = 2'd1; v.priv = 2'd2; v.hi = 2'd3; v.lo = 2'd1;
      apply(v, "R1 write above lower bound");
      v = base_hit(); v.acc = 2'd2; v.priv = 2'd1; v.hi = 2'd2; v.lo = 2'd1;
      apply(v, "R1 exec inside window");
      v = base_hit(); v.acc = 2'd2; v.priv = 2'd0; v.hi = 2'd2; v.lo = 2'd1;
      apply(v, "R1 exec below window");
      for (int ty = 0; ty < 8; ty++)
         for (int a = 0; a < 3; a++) begin
            v = base_hit(); v.ty = 3'(ty); v.acc = 2'(a);
            apply(v, "R2 type encoding");
         end
      v = base_hit(); v.pen = 1; v.aid = 31'h1234; v.acc = 2'd1;
      v.slots[0] = {16'h1234, 1'b1};
      apply(v, "R4 write-disabled match blocks write");
      v.acc = 2'd0; apply(v, "R4 write-disabled match narrows rights");
      v.slots[0] = {16'h1234, 1'b0}; v.acc = 2'd1;
      apply(v, "R4 full match allows write");
      v = base_hit(); v.pen = 1; v.aid = 31'h4001_5678; v.acc = 2'd1;
      v.slots[1] = {16'h5678, 1'b1}; v.slots[2] = {16'h5678, 1'b0};
      apply(v, "R5 high half before next register");
      v.slots[0] = {16'h5678, 1'b0};
      apply(v, "R5 low half wins first");
      v = base_hit(); v.pen = 1; v.aid = 31'h0; v.acc = 2'd1;
      apply(v, "R6 public page skips check");
      v.aid = 31'h77; v.pen = 0; apply(v, "R6 check disabled");
      v.pen = 1; v.acc = 2'd2; apply(v, "R7 fetch pid fault");
      v.acc = 2'd0; v.ty = 3'd1; apply(v, "R7 data pid fault keeps base rights");
      v = base_hit(); v.ty = 3'd0; v.acc = 2'd1; v.t = 1; v.d = 0;
      apply(v, "R8 rights fault skips later checks");
      v = base_hit(); v.acc = 2'd1; v.d = 0;
      apply(v, "R9 dirty fault");
      v.b = 1; apply(v, "R9 break overrides dirty");
      v.t = 1; apply(v, "R9 reference overrides break");
      v = base_hit(); v.acc = 2'd0; v.d = 0; v.b = 1;
      apply(v, "R10 write removed without fault");
      v = base_hit(); v.acc = 2'd2; v.priv = 2'd0; v.lo = 2'd0; v.t = 1;
      apply(v, "R10 trap leaves execute only");
      v = base_hit(); v.acc = 2'd3; v.t = 1; apply(v, "R11 alternate code as read");
      v.acc = 2'd3; v.t = 0; v.ty = 3'd4; apply(v, "R11 alternate code denied like read");

      for (int n = 0; n < 3000; n++) begin
         v = '0;
         v.hit = ($urandom % 8) != 0;
         v.acc = 2'($urandom); v.priv = 2'($urandom); v.ty = 3'($urandom);
         v.hi = 2'($urandom); v.lo = 2'($urandom);
         v.d = 1'($urandom); v.b = 1'($urandom); v.t = 1'($urandom);
         v.pen = 1'($urandom);
         for (int k = 0; k < 8; k++) v.slots[k] = {4'h0, 12'($urandom % 6), 1'($urandom)};
         v.aid = ($urandom % 4 == 0) ? 31'h0 : {15'($urandom), 4'h0, 12'($urandom % 8)};
         apply(v, "R9 random mix");
      end

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule